// File: doc/BRIEF.md
# Bus Cycle Termination Classifier

This block sits beside an asynchronous bus master and decides how each bus cycle ended. After a one-clock start pulse it watches the termination inputs: two data-size acknowledge lines, an autovector acknowledge, an external bus-error input and a halt input. It classifies the cycle from the order in which those signals arrive. The possible outcomes are a normal end, a halt, a bus error (before, with or instead of acknowledge), a late bus error (in the clock after acknowledge) or a retry (bus error together with halt).

A built-in bus monitor counts clocks while the cycle waits for termination. If nothing arrives within a limit chosen at cycle start, the monitor raises a bus error itself. The result is presented for exactly one clock with a valid strobe. When the outcome is a bus error, an exception request is raised alongside it. The block then returns to idle and waits for the next start.

Top module: `bus_term_classifier`

## Requirements
- R1: After reset, `outcome_valid` and `berr_exc` are 0 and `outcome` is 0; whenever `outcome_valid` is 0, `outcome` reads 0 and `berr_exc` is 0.
- R2: `cyc_start` is only accepted while idle. A start pulse during an active cycle does not restart the bus monitor. Termination inputs seen while idle produce no outcome.
- R3: Acknowledge is any of `ack_size[0]`, `ack_size[1]` or `ack_vec`. If acknowledge is sampled with bus error and halt negated (and halt not seen earlier), and bus error is still negated in the following clock, the outcome is normal (code 1). It is valid two clocks after the acknowledge was sampled, and `berr_exc` is 0.
- R4: If halt is sampled in the same clock as acknowledge, or in any earlier clock of the cycle, with bus error negated, the outcome is halt (code 2) with no exception.
- R5: If bus error is sampled without halt, before or together with acknowledge, the outcome is bus error (code 3). It is valid in the clock after the sample, with `berr_exc` = 1.
- R6: If bus error is sampled in the clock right after a clean acknowledge, the outcome is late bus error (code 4) with `berr_exc` = 1.
- R7: If bus error is sampled while halt is asserted in the same clock or was seen earlier in the cycle, the outcome is retry (code 5) with `berr_exc` = 0.
- R8: The bus monitor limit is 8 << `mon_sel` clocks (8, 16, 32, 64). `mon_sel` is captured at cycle start. With no termination, the outcome is bus error (code 3) with `berr_exc` = 1, valid exactly that many clocks after the start pulse is sampled.
- R9: A termination sampled on the monitor's final clock takes priority over the timeout.
- R10: `outcome_valid` lasts exactly one clock, after which the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse marking the start of a bus cycle |
| mon_sel | input | 2 | Bus monitor limit select, limit = 8 << mon_sel clocks |
| ack_size | input | 2 | Data-size acknowledge lines |
| ack_vec | input | 1 | Autovector acknowledge |
| berr_in | input | 1 | External bus error |
| halt_in | input | 1 | Halt input |
| outcome_valid | output | 1 | Outcome strobe, one clock |
| outcome | output | 3 | 1 normal, 2 halt, 3 bus error, 4 late bus error, 5 retry |
| berr_exc | output | 1 | Bus-error exception request, with the strobe |

## Verification
The hardest situation to reach from the ports is a collision between the bus monitor's last clock and a real termination. In that case the acknowledge must win over the timeout. The stimulus counts negative edges from the sampled start pulse and raises acknowledge exactly on the final monitor clock. The late bus error is reached the same way: bus error is raised on the clock after acknowledge. A start pulse issued mid-cycle, and a change to `mon_sel` after the start, both have to leave the timeout latency unchanged.

// File: rtl/bus_term_classifier.sv
module bus_term_classifier #(
  parameter int MON_BASE = 8,
  parameter int CNT_W    = $clog2(MON_BASE * 8) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic [1:0] mon_sel,
  input  logic [1:0] ack_size,
  input  logic       ack_vec,
  input  logic       berr_in,
  input  logic       halt_in,
  output logic       outcome_valid,
  output logic [2:0] outcome,
  output logic       berr_exc
);
  localparam logic [2:0] OC_NORMAL = 3'd1;
  localparam logic [2:0] OC_HALT   = 3'd2;
  localparam logic [2:0] OC_BERR   = 3'd3;
  localparam logic [2:0] OC_LATE   = 3'd4;
  localparam logic [2:0] OC_RETRY  = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LATE, S_DONE} state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sel_q;
  logic             halt_seen;
  logic [2:0]       res;
  logic             exc_q;

  wire              ack    = |ack_size | ack_vec;
  wire              halted = halt_in | halt_seen;
  wire [CNT_W-1:0]  limit  = CNT_W'(MON_BASE) << sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sel_q     <= '0;
      halt_seen <= 1'b0;
      res       <= '0;
      exc_q     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cyc_start) begin
          st        <= S_WAIT;
          cnt       <= '0;
          sel_q     <= mon_sel;
          halt_seen <= 1'b0;
        end
        S_WAIT: begin
          if (berr_in && halted) begin
            st <= S_DONE; res <= OC_RETRY; exc_q <= 1'b0;
          end else if (berr_in) begin
            st <= S_DONE; res <= OC_BERR; exc_q <= 1'b1;
          end else if (ack && halted) begin
            st <= S_DONE; res <= OC_HALT; exc_q <= 1'b0;
          end else if (ack) begin
            st <= S_LATE;
          end else if (cnt == limit - 1'b1) begin
            st <= S_DONE; res <= OC_BERR; exc_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
            if (halt_in) halt_seen <= 1'b1;
          end
        end
        S_LATE: begin
          st    <= S_DONE;
          res   <= berr_in ? OC_LATE : OC_NORMAL;
          exc_q <= berr_in;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign outcome_valid = (st == S_DONE);
  assign outcome       = outcome_valid ? res : 3'd0;
  assign berr_exc      = outcome_valid & exc_q;
endmodule

// File: rtl/bus_term_classifier_chk.sv
module bus_term_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ack_size,
  input logic       ack_vec,
  input logic       berr_in,
  input logic       outcome_valid,
  input logic [2:0] outcome,
  input logic       berr_exc
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !outcome_valid |-> (outcome == 3'd0 && !berr_exc));

  p_normal_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome_valid && outcome == 3'd1) |-> !$past(berr_in));

  p_halt_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome_valid && outcome == 3'd2) |-> ($past(|ack_size || ack_vec) && !$past(berr_in)));

  p_late_needs_berr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome_valid && outcome == 3'd4) |-> ($past(berr_in) && berr_exc));

  p_retry_no_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome_valid && outcome == 3'd5) |-> ($past(berr_in) && !berr_exc));

  p_exc_only_berr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    berr_exc |-> (outcome_valid && (outcome == 3'd3 || outcome == 3'd4)));

  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outcome_valid |=> !outcome_valid);
endmodule

bind bus_term_classifier bus_term_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_size(ack_size), .ack_vec(ack_vec),
  .berr_in(berr_in), .outcome_valid(outcome_valid), .outcome(outcome),
  .berr_exc(berr_exc)
);

// File: tb/bus_term_classifier_bench.sv
module bus_term_classifier_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic [1:0] mon_sel = 2'd0;
  logic [1:0] ack_size = 2'd0;
  logic       ack_vec = 1'b0;
  logic       berr_in = 1'b0;
  logic       halt_in = 1'b0;
  logic       outcome_valid;
  logic [2:0] outcome;
  logic       berr_exc;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bus_term_classifier u_bus_term_classifier (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] sel);
    @(negedge clk); cyc_start = 1'b1; mon_sel = sel;
    @(negedge clk); cyc_start = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] sz, input logic v, input logic b, input logic h);
    ack_size = sz; ack_vec = v; berr_in = b; halt_in = h;
    @(negedge clk);
    ack_size = 2'd0; ack_vec = 1'b0; berr_in = 1'b0; halt_in = 1'b0;
  endtask

  task automatic expect_result(input string req, input int code, input bit exc, input int lat);
    int cyc = 0;
    while (!outcome_valid && cyc < 300) begin
      @(negedge clk); cyc++;
    end
    check(outcome_valid, req, outcome_valid, 1);
    check(outcome == code, req, outcome, code);
    check(berr_exc == exc, req, berr_exc, exc);
    if (lat >= 0) check(cyc == lat, req, cyc, lat);
    @(negedge clk);
    check(!outcome_valid, "R10", outcome_valid, 0);
  endtask

  task automatic t_reset;
    check(!outcome_valid && outcome == 0 && !berr_exc, "R1", outcome, 0);
  endtask

  task automatic t_normal;
    start(2'd0); pulse(2'b01, 1'b0, 1'b0, 1'b0); expect_result("R3", 1, 1'b0, 1);
    start(2'd0); pulse(2'b10, 1'b0, 1'b0, 1'b0); expect_result("R3", 1, 1'b0, 1);
    start(2'd1); repeat (3) @(negedge clk);
    pulse(2'b00, 1'b1, 1'b0, 1'b0); expect_result("R3", 1, 1'b0, 1);
  endtask

  task automatic t_halt;
    start(2'd0); pulse(2'b00, 1'b0, 1'b0, 1'b1); @(negedge clk);
    pulse(2'b01, 1'b0, 1'b0, 1'b0); expect_result("R4", 2, 1'b0, 0);
    start(2'd0); pulse(2'b11, 1'b0, 1'b0, 1'b1); expect_result("R4", 2, 1'b0, 0);
  endtask

  task automatic t_berr;
    start(2'd0); pulse(2'b00, 1'b0, 1'b1, 1'b0); expect_result("R5", 3, 1'b1, 0);
    start(2'd0); pulse(2'b01, 1'b0, 1'b1, 1'b0); expect_result("R5", 3, 1'b1, 0);
  endtask

  task automatic t_late;
    start(2'd0);
    @(negedge clk); ack_size = 2'b10;
    @(negedge clk); ack_size = 2'b00; berr_in = 1'b1;
    @(negedge clk); berr_in = 1'b0;
    expect_result("R6", 4, 1'b1, 0);
  endtask

  task automatic t_retry;
    start(2'd0); pulse(2'b00, 1'b0, 1'b1, 1'b1); expect_result("R7", 5, 1'b0, 0);
    start(2'd0); pulse(2'b00, 1'b0, 1'b0, 1'b1); @(negedge clk);
    pulse(2'b00, 1'b0, 1'b1, 1'b0); expect_result("R7", 5, 1'b0, 0);
  endtask

  task automatic t_monitor;
    for (int s = 0; s < 4; s++) begin
      start(2'(s)); expect_result("R8", 3, 1'b1, 8 << s);
    end
    start(2'd0); mon_sel = 2'd3; expect_result("R8", 3, 1'b1, 8);
  endtask

  task automatic t_final_clock;
    start(2'd0); repeat (7) @(negedge clk);
    pulse(2'b01, 1'b0, 1'b0, 1'b0); expect_result("R9", 1, 1'b0, 1);
  endtask

  task automatic t_ignored;
    int seen = 0;
    start(2'd0); repeat (3) @(negedge clk);
    cyc_start = 1'b1; @(negedge clk); cyc_start = 1'b0;
    expect_result("R2", 3, 1'b1, 4);
    pulse(2'b01, 1'b0, 1'b0, 1'b0); pulse(2'b00, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (outcome_valid) seen++;
    end
    check(seen == 0, "R2", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_halt();
    t_berr();
    t_late();
    t_retry();
    t_monitor();
    t_final_clock();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule